// File: doc/BRIEF.md
# Mobile SDRAM Low-Power Mode Sequencer

This block sits on the controller side of a mobile SDRAM interface. It takes the memory into its low-power states and brings it back out. When the access path reports no transfer in flight, a power-down request lowers the clock-enable pin during a NOP cycle. The power-down kind depends on whether any bank has an open row: with every bank idle the result is precharge power-down, and with any row open it is active power-down. The device cannot refresh while it is powered down, so a watchdog with a programmable cycle limit forces the exit before the refresh interval runs out.

A separate deep power-down request issues the dedicated entry command and holds clock-enable low until a wake request arrives. The array contents are lost in this state. After waking, the block raises a reinitialization flag and holds it until the surrounding controller reports that the full power-up sequence has been replayed. Requests that arrive while the bus is busy are kept pending. Deep power-down wins over ordinary power-down when the banks allow it.

Top module: `pd_sequencer`

## Requirements
- R1: Power-down is entered only when `busy` was low at the deciding clock edge. Entry follows one cycle after the request is sampled. In the entry cycle `cke` is 0 and the command pins {cs_n,ras_n,cas_n,wee_n} read NOP = 0111.
- R2: `mode` encodes 0 = normal, 1 = precharge power-down, 2 = active power-down, 3 = deep power-down. An ordinary power-down reports 1 when all `bank_open` bits were 0 at the deciding edge, and 2 otherwise.
- R3: A `wake_req` sampled during a power-down hold cycle produces one exit cycle with `cke`=1, NOP on the pins and mode 0. The sequencer then returns to normal: `cke`=1, pins 1111 (deselect).
- R4: In ordinary power-down `cke` stays low for at most E consecutive cycles, where E = max(`wdog_limit`, 2) and the entry cycle counts. When no wake is present, the limit forces exactly E low cycles followed by a NOP exit cycle with `wdog_exit`=1.
- R5: The deep power-down command is `cke`=0 with pins 0110. It is issued only when every bank was idle and `busy` was low at the deciding edge. While any row is open the request stays pending, and it is issued once all banks close.
- R6: In deep power-down `cke` stays 0 and `mode` stays 3 until `wake_req`, whatever the watchdog limit.
- R7: Leaving deep power-down gives one cycle with `cke`=1, NOP and mode 0. `reinit_req` is 1 from that cycle until a cycle after `reinit_done` is sampled. No low-power request is taken while `reinit_req` is high.
- R8: A request sampled while `busy`=1 is held and serviced at the first edge with `busy`=0. When both kinds are pending and all banks are idle, deep power-down is taken and both requests are cleared. When banks are open, ordinary power-down is taken and the deep request stays pending.
- R9: After reset `cke`=1, the pins are 1111, `mode`=0, `reinit_req`=0, `wdog_exit`=0 and no request is pending.
- R10: When `wake_req` falls in the same cycle as watchdog expiry, the exit is the ordinary wake exit and `wdog_exit` stays 0.
- R11: `pd_req` and `dpd_req` sampled outside normal operation (during power-down or reinitialization) are dropped. After the exit the sequencer stays in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_open | input | NUM_BANKS | One bit per bank, 1 when a row is open |
| busy | input | 1 | An access is in progress |
| pd_req | input | 1 | Ordinary power-down request |
| dpd_req | input | 1 | Deep power-down request |
| wake_req | input | 1 | Request to leave the current low-power state |
| reinit_done | input | 1 | Power-up replay finished after deep power-down |
| wdog_limit | input | WDOG_W | Maximum clock-enable-low cycles in ordinary power-down |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mode | output | 2 | Current low-power mode |
| reinit_req | output | 1 | Full reinitialization required |
| wdog_exit | output | 1 | High in an exit cycle forced by the watchdog |

## Verification
A wake request and watchdog expiry can land in the same hold cycle. To provoke the collision, the bench raises `wake_req` in every hold cycle from the first up to the last one the limit allows. It expects the low-cycle count to equal the wake position and `wdog_exit` to stay low each time, including when the position coincides with the limit. The bench also raises both request kinds inside a single busy window, once with the banks idle and once with a row open. In each case it judges which entry command appears first when `busy` drops.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL    = 2'd0,
        MODE_PRECHG_PD = 2'd1,
        MODE_ACTIVE_PD = 2'd2,
        MODE_DEEP_PD   = 2'd3
    } pd_mode_e;

    typedef enum logic [1:0] {
        CMD_DESELECT = 2'd0,
        CMD_NOP      = 2'd1,
        CMD_DEEP_PD  = 2'd2
    } bus_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_PD_ENTER  = 3'd1,
        ST_PD_HOLD   = 3'd2,
        ST_PD_LEAVE  = 3'd3,
        ST_DPD_ENTER = 3'd4,
        ST_DPD_HOLD  = 3'd5,
        ST_DPD_LEAVE = 3'd6,
        ST_REINIT    = 3'd7
    } seq_state_e;

    typedef struct packed {
        logic      cke;
        bus_cmd_e  cmd;
        pd_mode_e  mode;
        logic      reinit;
    } pin_plan_t;

    function automatic cmd_pins_t encode_cmd(bus_cmd_e c);
        cmd_pins_t p;
        case (c)
            CMD_NOP:     p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_DEEP_PD: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
            default:     p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pd_req_arbiter.sv
module pd_req_arbiter
    import pdseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept_en,
    input  logic busy,
    input  logic any_open,
    input  logic pd_req,
    input  logic dpd_req,
    output logic go_pd,
    output logic go_dpd
);

    logic pd_pend_q, dpd_pend_q;
    logic want_pd, want_dpd;

    always_comb begin
        want_pd  = pd_pend_q  | (accept_en & pd_req);
        want_dpd = dpd_pend_q | (accept_en & dpd_req);
        go_dpd   = accept_en & ~busy & want_dpd & ~any_open;
        go_pd    = accept_en & ~busy & want_pd & ~go_dpd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_pend_q  <= 1'b0;
            dpd_pend_q <= 1'b0;
        end else if (go_dpd) begin
            pd_pend_q  <= 1'b0;
            dpd_pend_q <= 1'b0;
        end else if (go_pd) begin
            pd_pend_q  <= 1'b0;
            dpd_pend_q <= want_dpd;
        end else begin
            pd_pend_q  <= want_pd;
            dpd_pend_q <= want_dpd;
        end
    end

endmodule

// File: rtl/pd_refresh_watchdog.sv
module pd_refresh_watchdog #(
    parameter int WDOG_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [WDOG_W-1:0] limit,
    output logic              expired
);

    localparam logic [WDOG_W-1:0] MIN_LIMIT = WDOG_W'(2);
    localparam logic [WDOG_W-1:0] CNT_MAX   = '1;

    logic [WDOG_W-1:0] cnt_q;
    logic [WDOG_W-1:0] eff_limit;

    always_comb begin
        eff_limit = (limit < MIN_LIMIT) ? MIN_LIMIT : limit;
        expired   = (cnt_q >= eff_limit);
    end

    // cnt_q holds the number of clock-enable-low cycles so far, current one included
    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= WDOG_W'(1);
        end else if (advance && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + WDOG_W'(1);
        end
    end

endmodule

// File: rtl/pd_pin_decoder.sv
module pd_pin_decoder
    import pdseq_pkg::*;
(
    input  seq_state_e state,
    input  pd_mode_e   pd_kind,
    input  logic       wd_fired,
    output logic       cke,
    output cmd_pins_t  pins,
    output pd_mode_e   mode,
    output logic       reinit,
    output logic       wd_exit
);

    pin_plan_t plan;

    always_comb begin
        case (state)
            ST_PD_ENTER:  plan = '{cke: 1'b0, cmd: CMD_NOP,      mode: pd_kind,      reinit: 1'b0};
            ST_PD_HOLD:   plan = '{cke: 1'b0, cmd: CMD_DESELECT, mode: pd_kind,      reinit: 1'b0};
            ST_PD_LEAVE:  plan = '{cke: 1'b1, cmd: CMD_NOP,      mode: MODE_NORMAL,  reinit: 1'b0};
            ST_DPD_ENTER: plan = '{cke: 1'b0, cmd: CMD_DEEP_PD,  mode: MODE_DEEP_PD, reinit: 1'b0};
            ST_DPD_HOLD:  plan = '{cke: 1'b0, cmd: CMD_DESELECT, mode: MODE_DEEP_PD, reinit: 1'b0};
            ST_DPD_LEAVE: plan = '{cke: 1'b1, cmd: CMD_NOP,      mode: MODE_NORMAL,  reinit: 1'b1};
            ST_REINIT:    plan = '{cke: 1'b1, cmd: CMD_DESELECT, mode: MODE_NORMAL,  reinit: 1'b1};
            default:      plan = '{cke: 1'b1, cmd: CMD_DESELECT, mode: MODE_NORMAL,  reinit: 1'b0};
        endcase
        cke     = plan.cke;
        pins    = encode_cmd(plan.cmd);
        mode    = plan.mode;
        reinit  = plan.reinit;
        wd_exit = (state == ST_PD_LEAVE) && wd_fired;
    end

endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import pdseq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WDOG_W    = 23
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 busy,
    input  logic                 pd_req,
    input  logic                 dpd_req,
    input  logic                 wake_req,
    input  logic                 reinit_done,
    input  logic [WDOG_W-1:0]    wdog_limit,
    output logic                 cke,
    output logic                 cs_n,
    output logic                 ras_n,
    output logic                 cas_n,
    output logic                 we_n,
    output logic [1:0]           mode,
    output logic                 reinit_req,
    output logic                 wdog_exit
);

    seq_state_e state_q;
    pd_mode_e   kind_q;
    pd_mode_e   mode_w;
    logic       wd_fired_q;
    logic       any_open;
    logic       go_pd, go_dpd;
    logic       expired;
    cmd_pins_t  pins_w;

    assign any_open = |bank_open;

    pd_req_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .accept_en (state_q == ST_RUN),
        .busy      (busy),
        .any_open  (any_open),
        .pd_req    (pd_req),
        .dpd_req   (dpd_req),
        .go_pd     (go_pd),
        .go_dpd    (go_dpd)
    );

    pd_refresh_watchdog #(.WDOG_W(WDOG_W)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .load    (state_q == ST_RUN),
        .advance (state_q == ST_PD_ENTER || state_q == ST_PD_HOLD),
        .limit   (wdog_limit),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            kind_q     <= MODE_PRECHG_PD;
            wd_fired_q <= 1'b0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    wd_fired_q <= 1'b0;
                    if (go_dpd) begin
                        state_q <= ST_DPD_ENTER;
                    end else if (go_pd) begin
                        state_q <= ST_PD_ENTER;
                        kind_q  <= any_open ? MODE_ACTIVE_PD : MODE_PRECHG_PD;
                    end
                end
                ST_PD_ENTER:  state_q <= ST_PD_HOLD;
                ST_PD_HOLD: begin
                    if (wake_req || expired) begin
                        state_q    <= ST_PD_LEAVE;
                        wd_fired_q <= ~wake_req;
                    end
                end
                ST_PD_LEAVE:  state_q <= ST_RUN;
                ST_DPD_ENTER: state_q <= ST_DPD_HOLD;
                ST_DPD_HOLD:  if (wake_req) state_q <= ST_DPD_LEAVE;
                ST_DPD_LEAVE: state_q <= ST_REINIT;
                ST_REINIT:    if (reinit_done) state_q <= ST_RUN;
                default:      state_q <= ST_RUN;
            endcase
        end
    end

    pd_pin_decoder u_dec (
        .state    (state_q),
        .pd_kind  (kind_q),
        .wd_fired (wd_fired_q),
        .cke      (cke),
        .pins     (pins_w),
        .mode     (mode_w),
        .reinit   (reinit_req),
        .wd_exit  (wdog_exit)
    );

    assign cs_n  = pins_w.cs_n;
    assign ras_n = pins_w.ras_n;
    assign cas_n = pins_w.cas_n;
    assign we_n  = pins_w.we_n;
    assign mode  = mode_w;

endmodule

// File: rtl/pd_sequencer_checker.sv
module pd_sequencer_checker #(
    parameter int NUM_BANKS = 4,
    parameter int WDOG_W    = 23
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 busy,
    input logic [WDOG_W-1:0]    wdog_limit,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [1:0]           mode,
    input logic                 reinit_req,
    input logic                 wdog_exit
);

    logic [3:0]      pins;
    logic            is_nop, is_dpd, in_pd;
    logic [WDOG_W:0] low_run_q;
    logic [WDOG_W:0] eff_lim;

    assign pins    = {cs_n, ras_n, cas_n, we_n};
    assign is_nop  = (pins == 4'b0111);
    assign is_dpd  = (pins == 4'b0110);
    assign in_pd   = (mode == 2'd1) || (mode == 2'd2);
    assign eff_lim = (wdog_limit < WDOG_W'(2)) ? (WDOG_W+1)'(2) : {1'b0, wdog_limit};

    always_ff @(posedge clk) begin
        if (rst) low_run_q <= '0;
        else if (!cke && in_pd) low_run_q <= low_run_q + 1'b1;
        else low_run_q <= '0;
    end

    AST_CKE_FALL_WITH_NOP: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (is_nop || is_dpd)); // R1
    AST_CKE_RISE_WITH_NOP: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> is_nop); // R3
    AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (rst)
        (!cke && in_pd) |-> (low_run_q + 1'b1 <= eff_lim)); // R4
    AST_WDOG_EXIT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wdog_exit |-> (cke && is_nop && mode == 2'd0)); // R4
    AST_DPD_BANKS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cke && is_dpd) |-> ($past(bank_open) == '0 && !$past(busy))); // R5
    AST_DPD_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |-> !cke); // R6
    AST_DPD_EXIT_REINIT: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && $past(mode) == 2'd3) |-> reinit_req); // R7
    AST_REINIT_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $past(reinit_req) |-> cke); // R7

endmodule

bind pd_sequencer pd_sequencer_checker #(.NUM_BANKS(NUM_BANKS), .WDOG_W(WDOG_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .bank_open  (bank_open),
    .busy       (busy),
    .wdog_limit (wdog_limit),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .mode       (mode),
    .reinit_req (reinit_req),
    .wdog_exit  (wdog_exit)
);

// File: tb/test_pd_sequencer.sv
module test_pd_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int WW = 23;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_DES = 4'b1111;
    localparam logic [3:0] P_DPD = 4'b0110;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] bank_open = '0;
    logic          busy = 1'b0, pd_req = 1'b0, dpd_req = 1'b0;
    logic          wake_req = 1'b0, reinit_done = 1'b0;
    logic [WW-1:0] wdog_limit = WW'(1000);
    logic          cke, cs_n, ras_n, cas_n, we_n, reinit_req, wdog_exit;
    logic [1:0]    mode;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pd_sequencer #(.NUM_BANKS(NB), .WDOG_W(WW)) i_pd_sequencer (
        .clk(clk), .rst(rst), .bank_open(bank_open), .busy(busy),
        .pd_req(pd_req), .dpd_req(dpd_req), .wake_req(wake_req),
        .reinit_done(reinit_done), .wdog_limit(wdog_limit),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .mode(mode), .reinit_req(reinit_req), .wdog_exit(wdog_exit)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_pins(input string req, input logic exp_cke,
                              input logic [3:0] exp_pins, input logic [1:0] exp_mode);
        logic [3:0] p;
        p = {cs_n, ras_n, cas_n, we_n};
        check(cke == exp_cke, req, "cke", int'(cke), int'(exp_cke));
        check(p == exp_pins, req, "pins", int'(p), int'(exp_pins));
        check(mode == exp_mode, req, "mode", int'(mode), int'(exp_mode));
    endtask

    // Leave deep power-down and finish reinitialization (R7)
    task automatic leave_deep();
        wake_req = 1'b1; step(); wake_req = 1'b0;
        check_pins("R7", 1'b1, P_NOP, 2'd0);
        check(reinit_req == 1'b1, "R7", "reinit on exit", int'(reinit_req), 1);
        step();
        check(reinit_req == 1'b1, "R7", "reinit held", int'(reinit_req), 1);
        pd_req = 1'b1; dpd_req = 1'b1; step(); pd_req = 1'b0; dpd_req = 1'b0;
        step();
        check(cke == 1'b1 && reinit_req == 1'b1, "R11", "request during reinit", int'(cke), 1);
        reinit_done = 1'b1; step(); reinit_done = 1'b0;
        check(reinit_req == 1'b0, "R7", "reinit cleared", int'(reinit_req), 0);
        step(); step();
        check_pins("R11", 1'b1, P_DES, 2'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        check_pins("R9", 1'b1, P_DES, 2'd0);
        check(reinit_req == 1'b0 && wdog_exit == 1'b0, "R9", "flags", int'(reinit_req), 0);
        step(); step();
        check_pins("R9", 1'b1, P_DES, 2'd0);

        // Ordinary power-down over every bank pattern, wake exit (R1 R2 R3 R11)
        for (int bo = 0; bo < 16; bo++) begin
            bank_open = NB'(bo);
            pd_req = 1'b1; step(); pd_req = 1'b0;
            check_pins("R1", 1'b0, P_NOP, (bo == 0) ? 2'd1 : 2'd2);
            check(mode == ((bo == 0) ? 2'd1 : 2'd2), "R2", "kind", int'(mode), (bo == 0) ? 1 : 2);
            step();
            check_pins("R2", 1'b0, P_DES, (bo == 0) ? 2'd1 : 2'd2);
            pd_req = 1'b1; dpd_req = 1'b1; step(); pd_req = 1'b0; dpd_req = 1'b0;
            wake_req = 1'b1; step(); wake_req = 1'b0;
            check_pins("R3", 1'b1, P_NOP, 2'd0);
            check(wdog_exit == 1'b0, "R3", "wdog_exit on wake", int'(wdog_exit), 0);
            step();
            check_pins("R3", 1'b1, P_DES, 2'd0);
            step(); step();
            check_pins("R11", 1'b1, P_DES, 2'd0);
        end
        bank_open = '0;

        // Watchdog sweep (R4)
        for (int lim = 0; lim <= 8; lim++) begin
            int e;
            int lows;
            e = (lim < 2) ? 2 : lim;
            wdog_limit = WW'(lim);
            bank_open = NB'(lim % 2);
            pd_req = 1'b1; step(); pd_req = 1'b0;
            lows = 0;
            while (cke == 1'b0 && lows < 50) begin
                lows++;
                step();
            end
            check(lows == e, "R4", "low cycles", lows, e);
            check(wdog_exit == 1'b1, "R4", "wdog_exit", int'(wdog_exit), 1);
            check_pins("R4", 1'b1, P_NOP, 2'd0);
            step();
            check(wdog_exit == 1'b0, "R4", "wdog_exit pulse", int'(wdog_exit), 0);
        end
        bank_open = '0;

        // Wake at every hold position, including the expiry cycle (R10)
        wdog_limit = WW'(5);
        for (int j = 2; j <= 5; j++) begin
            pd_req = 1'b1; step(); pd_req = 1'b0;
            for (int k = 1; k < j; k++) step();
            check(cke == 1'b0, "R10", "still low", int'(cke), 0);
            wake_req = 1'b1; step(); wake_req = 1'b0;
            check_pins("R10", 1'b1, P_NOP, 2'd0);
            check(wdog_exit == 1'b0, "R10", "wake wins", int'(wdog_exit), 0);
            step();
        end
        wdog_limit = WW'(1000);

        // Busy deferral of ordinary power-down (R1 R8)
        busy = 1'b1;
        pd_req = 1'b1; step(); pd_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check(cke == 1'b1, "R1", "no entry while busy", int'(cke), 1);
            step();
        end
        busy = 1'b0; step();
        check_pins("R8", 1'b0, P_NOP, 2'd1);
        step();
        wake_req = 1'b1; step(); wake_req = 1'b0; step();

        // Both pending, banks idle: deep wins (R8 R5 R6)
        wdog_limit = WW'(3);
        busy = 1'b1;
        pd_req = 1'b1; dpd_req = 1'b1; step(); pd_req = 1'b0; dpd_req = 1'b0;
        step();
        busy = 1'b0; step();
        check_pins("R8", 1'b0, P_DPD, 2'd3);
        for (int k = 0; k < 20; k++) begin
            step();
            check_pins("R6", 1'b0, P_DES, 2'd3);
        end
        leave_deep();

        // Deep request deferred for every open-bank pattern (R5)
        for (int bo = 1; bo < 16; bo++) begin
            bank_open = NB'(bo);
            dpd_req = 1'b1; step(); dpd_req = 1'b0;
            check_pins("R5", 1'b1, P_DES, 2'd0);
            step(); step();
            check_pins("R5", 1'b1, P_DES, 2'd0);
            bank_open = '0; step();
            check_pins("R5", 1'b0, P_DPD, 2'd3);
            step();
            leave_deep();
        end

        // Both pending, row open: active power-down first, deep kept (R8)
        wdog_limit = WW'(1000);
        bank_open = 4'b0010;
        busy = 1'b1;
        pd_req = 1'b1; dpd_req = 1'b1; step(); pd_req = 1'b0; dpd_req = 1'b0;
        busy = 1'b0; step();
        check_pins("R8", 1'b0, P_NOP, 2'd2);
        step();
        wake_req = 1'b1; step(); wake_req = 1'b0;
        step(); step();
        check_pins("R8", 1'b1, P_DES, 2'd0);
        bank_open = '0; step();
        check_pins("R8", 1'b0, P_DPD, 2'd3);
        step();
        leave_deep();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule